// File: doc/BRIEF.md
# Dual-Channel DAC Serial Control Logic

This block is the digital front end of a two-channel digital-to-analogue converter. A host talks to it over a three-wire serial link: an active-low frame select, a serial clock and a serial data line. All three are brought into the faster system clock through synchronisers. Edge detection on the synchronised serial clock drives a 24-bit shift register and an execute step. Each 24-bit word carries an 8-bit control byte and a 16-bit data field.

The block is double-buffered. Every accepted word writes one of two channel buffers, either with a 16-bit code or with a power-down command. Independent load bits then copy a buffer into that channel's DAC register and operating mode. Both channels can be loaded by the same word, which gives a simultaneous update. Loads in separate words give a sequential update.

The outputs are the two 16-bit DAC codes, the two 2-bit mode fields and an error flag for words with a bad reserved field. A frame that ends early is dropped without any effect. Analogue behaviour is outside the block; power-down appears only as a mode code.

Top module: `twin_dac_front`

## Requirements
- R1: While `frameN` is low, each falling edge of `serClk` samples `serData` into the command word, most significant bit (bit 23) first. Each high and each low phase of `serClk` lasts at least two system clock cycles.
- R2: The command executes on the 24th falling edge of a frame. Its results appear on the outputs after exactly SYNC_STAGES+1 rising edges of `clk` (3 with the defaults) counted from that serial clock edge.
- R3: If `frameN` rises before the 24th falling edge, the partial word is discarded: no buffer, DAC code, mode or error flag changes. The next frame starts from an empty shift register.
- R4: Word fields: bits 23:22 reserved, bit 21 loads channel B, bit 20 loads channel A, bit 19 is ignored, bit 18 selects the target buffer (0 = A, 1 = B), bits 17:16 hold the mode code, bits 15:0 hold the data code.
- R5: A word with mode code 00 writes its data code into the selected buffer and sets that buffer's mode to 00. A buffer write alone leaves the outputs unchanged.
- R6: A word with a nonzero mode code writes that code into the selected buffer as a power-down command. The buffer's stored data code is kept.
- R7: Each set load bit copies that channel's buffer, as updated by the same word, into the channel's outputs. Both load bits set update both channels on the same clock edge.
- R8: Loading a buffer that holds a power-down command sets the channel mode to the command code and leaves the channel's DAC code unchanged.
- R9: Mode codes are 00 normal, 01 about 1 kΩ to ground, 10 about 100 kΩ to ground and 11 high impedance. The two channels' modes are independent.
- R10: After reset both DAC codes are 0, both modes are 00 and `cmdError` is 0.
- R11: A channel leaves power-down only through a load of a buffer that has received a mode-00 data write. Loading a buffer that still holds a power-down command keeps the channel powered down.
- R12: A word with either reserved bit set is ignored entirely and sets `cmdError` to 1. The next executed word with both reserved bits zero clears it.
- R13: Falling edges after the 24th within one frame are ignored until `frameN` goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Serial frame select, active low, asynchronous to clk |
| serClk | input | 1 | Serial clock, data sampled on its falling edge |
| serData | input | 1 | Serial data, MSB first |
| dacValA | output | 16 | Channel A DAC register code |
| dacValB | output | 16 | Channel B DAC register code |
| modeA | output | 2 | Channel A operating mode code |
| modeB | output | 2 | Channel B operating mode code |
| cmdError | output | 1 | Last executed word had a nonzero reserved field |

## Verification
Every result is due three system clock edges after the serial clock falls: two synchroniser stages, then the register update. The bench changes inputs on falling `clk` edges. For the timing check it samples on the falling edge after the second rising edge, where the old value must still be present, and again after the third, where the new value must be present. Every other check waits several cycles after a word completes, and for aborted frames after the frame closes, so all results are settled when sampled. The abort and extra-edge tests are each followed by a word whose result would be corrupted by any leftover shift-register content or by a second execute.

// File: rtl/twin_dac_pkg.sv
package twin_dac_pkg;
  localparam int DATA_W   = 16;
  localparam int CTRL_W   = 8;
  localparam int FRAME_W  = DATA_W + CTRL_W;
  localparam int MODE_W   = 2;
  localparam int NUM_CH   = 2;
  // bit positions inside the command word
  localparam int MODE_LSB = DATA_W;
  localparam int SEL_BIT  = DATA_W + 2;
  localparam int LOAD_LSB = DATA_W + 4;
  localparam int RSV_LSB  = DATA_W + 6;

  typedef struct packed {
    logic clear;    // frame closed: empty the shift register
    logic shiftEn;  // take one serial bit
    logic lastBit;  // the bit being taken completes the word
    logic serBit;   // synchronised serial data
  } strobe_t;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [DATA_W-1:0] data;
  } chan_buf_t;
endpackage

// File: rtl/twin_dac_sync.sv
module twin_dac_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/twin_dac_ctrl.sv
module twin_dac_ctrl
  import twin_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameN,
  input  logic    serClk,
  input  logic    serData,
  output strobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic frameSync, clkSync, dataSync;
  logic clkPrev, fallSeen, frameLive;
  logic [CNT_W-1:0] bitCnt;

  twin_dac_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uFrameSync (
    .clk(clk), .rstN(rstN), .din(frameN), .dout(frameSync));
  twin_dac_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uClkSync (
    .clk(clk), .rstN(rstN), .din(serClk), .dout(clkSync));
  twin_dac_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uDataSync (
    .clk(clk), .rstN(rstN), .din(serData), .dout(dataSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkSync;
  end

  assign fallSeen  = clkPrev & ~clkSync;
  assign frameLive = ~frameSync;

  // bit counter saturates at a full word; only a closed frame rearms it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  bitCnt <= '0;
    else if (!frameLive)                        bitCnt <= '0;
    else if (fallSeen && (bitCnt != FULL_CNT))  bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe.clear   = ~frameLive;
    strobe.shiftEn = frameLive & fallSeen & (bitCnt != FULL_CNT);
    strobe.lastBit = (bitCnt == LAST_IDX);
    strobe.serBit  = dataSync;
  end
endmodule

// File: rtl/twin_dac_dpath.sv
module twin_dac_dpath
  import twin_dac_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  output logic [NUM_CH-1:0][DATA_W-1:0] dacVal,
  output logic [NUM_CH-1:0][MODE_W-1:0] chanMode,
  output logic                          cmdError
);
  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] wordNext;
  logic               execNow, rsvBad, accept, bufSel;
  logic [MODE_W-1:0]  pdCode;
  logic [DATA_W-1:0]  dataIn;
  logic [NUM_CH-1:0]  loadBits;

  assign wordNext = {shiftReg, strobe.serBit};
  assign execNow  = strobe.shiftEn & strobe.lastBit;
  assign rsvBad   = |wordNext[FRAME_W-1:RSV_LSB];
  assign accept   = execNow & ~rsvBad;
  assign bufSel   = wordNext[SEL_BIT];
  assign pdCode   = wordNext[MODE_LSB +: MODE_W];
  assign dataIn   = wordNext[DATA_W-1:0];
  assign loadBits = wordNext[LOAD_LSB +: NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.clear)   shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= wordNext[FRAME_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cmdError <= 1'b0;
    else if (execNow) cmdError <= rsvBad;
  end

  genvar ch;
  for (ch = 0; ch < NUM_CH; ch++) begin : gChan
    chan_buf_t         bufQ, bufNext;
    logic [DATA_W-1:0] dacQ;
    logic [MODE_W-1:0] modeQ;
    logic              selHit;

    assign selHit = (int'(bufSel) == ch);

    // buffer contents as seen by a load in the same word
    always_comb begin
      bufNext = bufQ;
      if (accept && selHit) begin
        if (pdCode == '0) begin
          bufNext.mode = '0;
          bufNext.data = dataIn;
        end else begin
          bufNext.mode = pdCode;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ  <= '0;
        dacQ  <= '0;
        modeQ <= '0;
      end else begin
        bufQ <= bufNext;
        if (accept && loadBits[ch]) begin
          modeQ <= bufNext.mode;
          if (bufNext.mode == '0) dacQ <= bufNext.data;
        end
      end
    end

    assign dacVal[ch]   = dacQ;
    assign chanMode[ch] = modeQ;
  end
endmodule

// File: rtl/twin_dac_front.sv
module twin_dac_front
  import twin_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              serClk,
  input  logic              serData,
  output logic [DATA_W-1:0] dacValA,
  output logic [DATA_W-1:0] dacValB,
  output logic [MODE_W-1:0] modeA,
  output logic [MODE_W-1:0] modeB,
  output logic              cmdError
);
  strobe_t                       ctrlStrobe;
  logic [NUM_CH-1:0][DATA_W-1:0] dacVal;
  logic [NUM_CH-1:0][MODE_W-1:0] chanMode;

  twin_dac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .serClk(serClk),
    .serData(serData), .strobe(ctrlStrobe));

  twin_dac_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe),
    .dacVal(dacVal), .chanMode(chanMode), .cmdError(cmdError));

  assign dacValA = dacVal[0];
  assign dacValB = dacVal[1];
  assign modeA   = chanMode[0];
  assign modeB   = chanMode[1];
endmodule

// File: rtl/twin_dac_chk.sv
module twin_dac_chk
  import twin_dac_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           strobe,
  input logic [DATA_W-1:0] dacValA,
  input logic [DATA_W-1:0] dacValB,
  input logic [MODE_W-1:0] modeA,
  input logic [MODE_W-1:0] modeB,
  input logic              cmdError
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  logic [CNT_W-1:0] shiftCnt;

  // independent count of bits taken in the current frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftCnt <= '0;
    else if (strobe.clear)   shiftCnt <= '0;
    else if (strobe.shiftEn) shiftCnt <= shiftCnt + 1'b1;
  end

  AST_EXEC_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && strobe.lastBit) |-> (shiftCnt == CNT_W'(FRAME_W - 1))); // R2

  AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |-> (shiftCnt < CNT_W'(FRAME_W))); // R13

  AST_OUT_ONLY_ON_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftEn && strobe.lastBit) |=> ($stable(dacValA) && $stable(dacValB)
      && $stable(modeA) && $stable(modeB))); // R3

  AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdError) |-> ($stable(dacValA) && $stable(dacValB)
      && $stable(modeA) && $stable(modeB))); // R12

  AST_PD_HOLDS_CODE_A: assert property (@(posedge clk) disable iff (!rstN)
    (modeA != '0) |-> $stable(dacValA)); // R8

  AST_PD_HOLDS_CODE_B: assert property (@(posedge clk) disable iff (!rstN)
    (modeB != '0) |-> $stable(dacValB)); // R8
endmodule

bind twin_dac_front twin_dac_chk uChk (
  .clk(clk), .rstN(rstN), .strobe(ctrlStrobe),
  .dacValA(dacValA), .dacValB(dacValB), .modeA(modeA), .modeB(modeB),
  .cmdError(cmdError));

// File: tb/twin_dac_front_test.sv
`timescale 1ns/1ps
module twin_dac_front_test;
  logic        clk = 1'b0;
  logic        rstN, frameN, serClk, serData;
  logic [15:0] dacValA, dacValB;
  logic [1:0]  modeA, modeB;
  logic        cmdError;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  twin_dac_front uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .serClk(serClk), .serData(serData),
    .dacValA(dacValA), .dacValB(dacValB), .modeA(modeA), .modeB(modeB),
    .cmdError(cmdError));

  // {word[23:0], dacA, dacB, modeA, modeB, err} expected after each word
  localparam int NVEC = 14;
  localparam logic [60:0] VEC [NVEC] = '{
    {24'h001234, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0},  // R5 buffer A write, no load
    {24'h045678, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0},  // R5 buffer B write, no load
    {24'h345678, 16'h1234, 16'h5678, 2'd0, 2'd0, 1'b0},  // R7 both channels at once
    {24'h10ABCD, 16'hABCD, 16'h5678, 2'd0, 2'd0, 1'b0},  // R7 write and load same word
    {24'h21FFFF, 16'hABCD, 16'h5678, 2'd0, 2'd0, 1'b0},  // R6 pd into A, load B only
    {24'h130000, 16'hABCD, 16'h5678, 2'd3, 2'd0, 1'b0},  // R8 A to high impedance
    {24'h260000, 16'hABCD, 16'h5678, 2'd3, 2'd2, 1'b0},  // R9 B to 100k, A independent
    {24'h149999, 16'hABCD, 16'h5678, 2'd3, 2'd2, 1'b0},  // R11 reload A still down
    {24'h200000, 16'hABCD, 16'h9999, 2'd3, 2'd0, 1'b0},  // R11 B wakes with buffered code
    {24'h184321, 16'h4321, 16'h9999, 2'd0, 2'd0, 1'b0},  // R4 bit 19 ignored, A wakes
    {24'hB01111, 16'h4321, 16'h9999, 2'd0, 2'd0, 1'b1},  // R12 bit 23 set
    {24'h702222, 16'h4321, 16'h9999, 2'd0, 2'd0, 1'b1},  // R12 bit 22 set
    {24'h3D0000, 16'h4321, 16'h9999, 2'd0, 2'd1, 1'b0},  // R9 B to 1k, error cleared
    {24'h120000, 16'h4321, 16'h9999, 2'd2, 2'd1, 1'b0}   // R8 A to 100k
  };

  function automatic string vecTag(input int idx);
    case (idx)
      0, 1:    return "R5";
      2, 3:    return "R7";
      4:       return "R6";
      5, 13:   return "R8";
      6, 12:   return "R9";
      7, 8:    return "R11";
      9:       return "R4";
      default: return "R12";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic [15:0] expA, input logic [15:0] expB,
                          input logic [1:0] expMa, input logic [1:0] expMb, input logic expErr);
    vectors++;
    if (dacValA !== expA || dacValB !== expB || modeA !== expMa || modeB !== expMb
        || cmdError !== expErr) begin
      miscompares++;
      $display("FAIL %s: got A=%h B=%h mA=%0d mB=%0d err=%0d, expected A=%h B=%h mA=%0d mB=%0d err=%0d",
               tag, dacValA, dacValB, modeA, modeB, cmdError,
               expA, expB, expMa, expMb, expErr);
    end
  endtask

  task automatic oneBit(input logic b);
    @(negedge clk);
    serData = b;
    serClk  = 1'b1;
    repeat (3) @(negedge clk);
    serClk  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBits(input logic [23:0] w, input int n);
    for (int i = 23; i > 23 - n; i--) oneBit(w[i]);
  endtask

  task automatic frameOpen();
    @(negedge clk);
    frameN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic frameClose();
    repeat (4) @(negedge clk);
    frameN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendWord(input logic [23:0] w);
    frameOpen();
    sendBits(w, 24);
    frameClose();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameN = 1'b1; serClk = 1'b0; serData = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkOut("R10 reset", 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      sendWord(VEC[v][60:37]);
      checkOut(vecTag(v), VEC[v][36:21], VEC[v][20:5], VEC[v][4:3], VEC[v][2:1], VEC[v][0]);
    end

    // R3: abort after 12 bits of a word that would load both channels
    frameOpen();
    sendBits(24'h34AAAA, 12);
    frameClose();
    checkOut("R3 abort", 16'h4321, 16'h9999, 2'd2, 2'd1, 1'b0);
    // R1: following word must see a clean shift register
    sendWord(24'h105555);
    checkOut("R1 after abort", 16'h5555, 16'h9999, 2'd0, 2'd1, 1'b0);

    // R13: 24 extra edges in the same frame carry a word that would zero A
    frameOpen();
    sendBits(24'h247777, 24);
    sendBits(24'h300000, 24);
    frameClose();
    checkOut("R13 extra edges", 16'h5555, 16'h7777, 2'd0, 2'd0, 1'b0);

    // R2: exact latency from the last serial falling edge
    frameOpen();
    sendBits(24'h100F0F, 23);
    @(negedge clk);
    serData = 1'b1;
    serClk  = 1'b1;
    repeat (3) @(negedge clk);
    serClk  = 1'b0;
    repeat (2) @(negedge clk);
    checkOut("R2 before third edge", 16'h5555, 16'h7777, 2'd0, 2'd0, 1'b0);
    @(negedge clk);
    checkOut("R2 at third edge", 16'h0F0F, 16'h7777, 2'd0, 2'd0, 1'b0);
    frameClose();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule